// File: doc/BRIEF.md
# Framed Synchronous Serial Host Port

This block is the host-facing serial port of a sampled front end. It is the timing master of the link. It produces the serial clock and a frame sync, and it exchanges sixteen-bit words with a DSP host. Every sample period holds two frames. A data frame sends one receive sample to the host and takes one transmit sample back. A control frame, placed between two data frames, lets the host read or write a small file of eight-bit registers. Register 0 holds the front-end enable.

Three static pins set the framing. The first chooses whether the frame sync comes one serial-clock cycle ahead of the first bit or in the same cycle as it. The second places the control frame a quarter or half of the way through the sample period. The third stops the serial clock once thirty-two cycles have run after each frame sync, so the host sees clock only around frames. All timing runs on one system clock, and the serial clock runs at half its rate. The pins are meant to be set while the block is held in reset. The sample period, in serial-clock cycles, must be a power of two.

Top module: `host_serial_port`

## Requirements
- R1: While reset is held and right after it, sclk_o, fs_o, sdout_o and tx_valid_o are low.
- R2: With clock stopping off, data-frame syncs repeat every PERIOD serial-clock cycles, which is 2*PERIOD system clocks (256 by default).
- R3: A data frame sends rx_sample_i, captured at the first bit, on sdout_o with the most significant bit first. It takes 16 bits from sdin_i, most significant first, into tx_sample_o. tx_valid_o pulses for one clock after the 16th bit.
- R4: With fs_early_i=1 the sync is high during the serial-clock cycle just before the first bit, and sdout_o is 0 in that cycle. With fs_early_i=0 the sync is high during the first-bit cycle itself. Either way the sync lasts exactly one serial-clock cycle.
- R5: The control-frame sync follows the data-frame sync by PERIOD/4 serial-clock cycles when ctrl_pos_i=1, and by PERIOD/2 cycles when ctrl_pos_i=0.
- R6: With sclk_stop_i=1, sclk_o gives exactly 32 rising edges per sync, starting in the sync cycle, and then stays low. With sclk_stop_i=0 it runs without a break.
- R7: The host's control word is, first bit to last: a direction bit (1 read, 0 write), a 7-bit address, and 8 data bits. During a read, sdout_o carries 0 for the first 8 bits and the addressed register, most significant bit first, for the last 8. Addresses at or above NREGS read as 0, and writes to them have no effect.
- R8: A register write takes effect only at the falling serial-clock edge that samples the 16th bit of a control frame. It is not visible before that edge.
- R9: Register 0 resets to 08h and all other registers reset to 00h. Bit 7 of register 0 drives fe_en_o.
- R10: While fe_en_o is 0, frames keep running and registers can still be read and written.
- R11: sdout_o and fs_o change only together with a rising edge of sclk_o. sdin_i is sampled on the falling edge, so a change on sdin_i after that edge has no effect on the received bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_early_i | input | 1 | 1: sync one cycle before the first bit; 0: sync on the first bit |
| ctrl_pos_i | input | 1 | 1: control frame at a quarter period; 0: at half period |
| sclk_stop_i | input | 1 | Stop the serial clock 32 cycles after each sync |
| sdin_i | input | 1 | Serial data from the host |
| rx_sample_i | input | 16 | Receive sample to send in the next data frame |
| sclk_o | output | 1 | Serial clock to the host |
| fs_o | output | 1 | Frame sync |
| sdout_o | output | 1 | Serial data to the host |
| tx_sample_o | output | 16 | Last transmit sample received |
| tx_valid_o | output | 1 | One-clock pulse when tx_sample_o is updated |
| fe_en_o | output | 1 | Front-end enable, bit 7 of register 0 |

## Verification
The assertions watch several properties on every cycle. They check that the sync starts only with a serial-clock rise and lasts one serial-clock cycle, that outgoing data moves only on rising edges, and that the clock never stays high for two system clocks. They also check that the transmit word changes only with its one-clock valid pulse, and that a register change appears only at a falling serial-clock edge. The bench scenarios show what needs counting across a frame or a period: the period length and control-frame offset for both position settings, the 32-edge window when the clock is stopped, and bit order in both directions. They also cover the empty first half of a read response, the rejected out-of-range write, the sync placement for each mode, and commit timing seen from outside the block.

// File: rtl/host_serial_port_pkg.sv
`timescale 1ns/1ps
package host_serial_port_pkg;
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_DATA = 2'd1,
        SLOT_CTRL = 2'd2
    } slot_e;
endpackage

// File: rtl/hsp_timer.sv
`timescale 1ns/1ps
module hsp_timer
    import host_serial_port_pkg::*;
#(
    parameter int PERIOD = 128,
    parameter int WORD   = 16,
    parameter int RUN    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fs_early_i,
    input  logic                     ctrl_pos_i,
    input  logic                     sclk_stop_i,
    output logic                     sclk_o,
    output logic                     fs_o,
    output logic                     rise_o,
    output logic                     fall_o,
    output slot_e                    slot_o,
    output logic [$clog2(WORD)-1:0]  bit_idx_o
);
    localparam int CW = $clog2(PERIOD);
    localparam int IW = $clog2(WORD);
    localparam logic [CW-1:0] RUN_C  = CW'(RUN);
    localparam logic [CW-1:0] WORD_C = CW'(WORD);

    typedef struct packed {
        logic          ph;
        logic [CW-1:0] cnt;
        logic          sclk;
        logic          fs;
    } tmr_t;

    tmr_t q, d;
    logic [CW-1:0] ctrl_start, data_fs_at, ctrl_fs_at;
    logic [CW-1:0] data_off, ctrl_off, data_win, ctrl_win;
    logic          in_window;

    always_comb begin
        ctrl_start = ctrl_pos_i ? CW'(PERIOD / 4) : CW'(PERIOD / 2);
        data_fs_at = fs_early_i ? CW'(PERIOD - 1) : '0;
        ctrl_fs_at = ctrl_start - CW'(fs_early_i);
        data_off   = q.cnt;
        ctrl_off   = q.cnt - ctrl_start;
        data_win   = q.cnt - data_fs_at;
        ctrl_win   = q.cnt - ctrl_fs_at;
        in_window  = (data_win < RUN_C) || (ctrl_win < RUN_C);

        slot_o    = SLOT_IDLE;
        bit_idx_o = '0;
        if (data_off < WORD_C) begin
            slot_o    = SLOT_DATA;
            bit_idx_o = data_off[IW-1:0];
        end else if (ctrl_off < WORD_C) begin
            slot_o    = SLOT_CTRL;
            bit_idx_o = ctrl_off[IW-1:0];
        end

        d    = q;
        d.ph = ~q.ph;
        if (!q.ph) begin
            d.sclk = in_window | ~sclk_stop_i;
            d.fs   = (q.cnt == data_fs_at) || (q.cnt == ctrl_fs_at);
        end else begin
            d.sclk = 1'b0;
            d.cnt  = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rise_o = ~q.ph;
    assign fall_o = q.ph;
    assign sclk_o = q.sclk;
    assign fs_o   = q.fs;
endmodule

// File: rtl/hsp_regs.sv
`timescale 1ns/1ps
module hsp_regs #(
    parameter int          NREGS = 8,
    parameter int          AW    = 7,
    parameter int          DW    = 8,
    parameter logic [7:0]  RST0  = 8'h08
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o,
    output logic          fe_en_o
);
    typedef logic [NREGS-1:0][DW-1:0] file_t;

    file_t q, d;

    always_comb begin
        d       = q;
        rdata_o = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (we_i && (waddr_i == AW'(i))) begin
                d[i] = wdata_i;
            end
            if (raddr_i == AW'(i)) begin
                rdata_o = q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q[0] <= DW'(RST0);
        end else begin
            q <= d;
        end
    end

    assign fe_en_o = q[0][DW-1];
endmodule

// File: rtl/host_serial_port.sv
`timescale 1ns/1ps
module host_serial_port
    import host_serial_port_pkg::*;
#(
    parameter int PERIOD = 128,
    parameter int NREGS  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fs_early_i,
    input  logic        ctrl_pos_i,
    input  logic        sclk_stop_i,
    input  logic        sdin_i,
    input  logic [15:0] rx_sample_i,
    output logic        sclk_o,
    output logic        fs_o,
    output logic        sdout_o,
    output logic [15:0] tx_sample_o,
    output logic        tx_valid_o,
    output logic        fe_en_o
);
    localparam int WORD = 16;
    localparam int IW   = $clog2(WORD);
    localparam int AW   = 7;
    localparam int DW   = 8;
    localparam int SHW  = WORD - 1;
    localparam logic [IW-1:0] LAST   = IW'(WORD - 1);
    localparam logic [IW-1:0] ADDR_E = IW'(AW);

    typedef struct packed {
        logic            sdout;
        logic [WORD-1:0] sreg;
        logic [SHW-1:0]  shin;
        logic            rw;
        logic [AW-1:0]   addr;
        logic [WORD-1:0] tx_word;
        logic            tx_valid;
    } port_t;

    port_t q, d;

    logic          rise, fall;
    slot_e         slot;
    logic [IW-1:0] idx;
    logic          we;
    logic [DW-1:0] wdata, rdata;

    hsp_timer #(.PERIOD(PERIOD), .WORD(WORD), .RUN(2 * WORD)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .fs_early_i  (fs_early_i),
        .ctrl_pos_i  (ctrl_pos_i),
        .sclk_stop_i (sclk_stop_i),
        .sclk_o      (sclk_o),
        .fs_o        (fs_o),
        .rise_o      (rise),
        .fall_o      (fall),
        .slot_o      (slot),
        .bit_idx_o   (idx)
    );

    hsp_regs #(.NREGS(NREGS), .AW(AW), .DW(DW), .RST0(8'h08)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .waddr_i (q.addr),
        .wdata_i (wdata),
        .raddr_i (q.addr),
        .rdata_o (rdata),
        .fe_en_o (fe_en_o)
    );

    always_comb begin
        d          = q;
        d.tx_valid = 1'b0;
        we         = 1'b0;
        wdata      = {q.shin[DW-2:0], sdin_i};
        if (rise) begin
            d.sdout = 1'b0;
            case (slot)
                SLOT_DATA: begin
                    if (idx == '0) begin
                        d.sreg  = rx_sample_i;
                        d.sdout = rx_sample_i[WORD-1];
                    end else begin
                        d.sdout = q.sreg[~idx];
                    end
                end
                SLOT_CTRL: begin
                    if (idx[IW-1]) begin
                        d.sdout = rdata[~idx[IW-2:0]];
                    end
                end
                default: d.sdout = 1'b0;
            endcase
        end else if (fall && (slot != SLOT_IDLE)) begin
            d.shin = {q.shin[SHW-2:0], sdin_i};
            if (slot == SLOT_DATA && idx == LAST) begin
                d.tx_word  = {q.shin, sdin_i};
                d.tx_valid = 1'b1;
            end
            if (slot == SLOT_CTRL && idx == ADDR_E) begin
                d.rw   = q.shin[AW-1];
                d.addr = {q.shin[AW-2:0], sdin_i};
            end
            if (slot == SLOT_CTRL && idx == LAST && !q.rw) begin
                we = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sdout_o     = q.sdout;
    assign tx_sample_o = q.tx_word;
    assign tx_valid_o  = q.tx_valid;
endmodule

// File: rtl/host_serial_port_chk.sv
`timescale 1ns/1ps
module host_serial_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sclk_o,
    input logic        fs_o,
    input logic        sdout_o,
    input logic [15:0] tx_sample_o,
    input logic        tx_valid_o,
    input logic        fe_en_o
);
    p_fs_with_sclk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_o) |-> $rose(sclk_o));

    p_fs_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_o) |-> ##2 !fs_o);

    p_sdout_on_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdout_o) |-> $rose(sclk_o));

    p_sclk_half_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |=> !sclk_o);

    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |=> !tx_valid_o);

    p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_sample_o) |-> tx_valid_o);

    p_commit_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fe_en_o) |-> $fell(sclk_o));
endmodule

bind host_serial_port host_serial_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_o      (sclk_o),
    .fs_o        (fs_o),
    .sdout_o     (sdout_o),
    .tx_sample_o (tx_sample_o),
    .tx_valid_o  (tx_valid_o),
    .fe_en_o     (fe_en_o)
);

// File: tb/host_serial_port_tb.sv
`timescale 1ns/1ps
module host_serial_port_tb;
    localparam int PERIOD = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fs_early_i = 1'b0;
    logic        ctrl_pos_i = 1'b0;
    logic        sclk_stop_i = 1'b0;
    logic        sdin_i = 1'b0;
    logic [15:0] rx_sample_i = '0;
    logic        sclk_o, fs_o, sdout_o, tx_valid_o, fe_en_o;
    logic [15:0] tx_sample_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  fs_seen = 0;
    int  cyc     = 0;
    bit  valid_seen = 1'b0;
    bit  done = 1'b0;
    logic sd_at_fs, fe_mid;

    host_serial_port #(.PERIOD(PERIOD), .NREGS(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .fs_early_i(fs_early_i), .ctrl_pos_i(ctrl_pos_i),
        .sclk_stop_i(sclk_stop_i), .sdin_i(sdin_i), .rx_sample_i(rx_sample_i),
        .sclk_o(sclk_o), .fs_o(fs_o), .sdout_o(sdout_o), .tx_sample_o(tx_sample_o),
        .tx_valid_o(tx_valid_o), .fe_en_o(fe_en_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge fs_o) fs_seen = fs_seen + 1;
    always @(posedge tx_valid_o) valid_seen = 1'b1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit early, input bit pos, input bit stop);
        @(negedge clk);
        rst_n = 1'b0;
        fs_early_i = early;
        ctrl_pos_i = pos;
        sclk_stop_i = stop;
        repeat (3) @(negedge clk);
        fs_seen = 0;
        rst_n = 1'b1;
    endtask

    function automatic bit fs_is_ctrl(input int n);
        return fs_early_i ? (n % 2 == 1) : (n % 2 == 0);
    endfunction

    task automatic wait_fs(input bit want_ctrl);
        forever begin
            @(posedge sclk_o);
            #2;
            if (fs_o && (fs_is_ctrl(fs_seen) == want_ctrl)) break;
        end
    endtask

    task automatic xfer(input bit want_ctrl, input logic [15:0] din, input bit glitch,
                        output logic [15:0] dout);
        valid_seen = 1'b0;
        wait_fs(want_ctrl);
        sd_at_fs = sdout_o;
        if (fs_early_i) begin
            @(posedge sclk_o);
            #2;
        end
        for (int i = 0; i < 16; i++) begin
            dout[15-i] = sdout_o;
            sdin_i = din[15-i];
            if (i == 15) fe_mid = fe_en_o;
            @(negedge sclk_o);
            #2;
            if (glitch) sdin_i = ~sdin_i;
            if (i < 15) begin
                @(posedge sclk_o);
                #2;
            end
        end
    endtask

    task automatic reg_write(input logic [6:0] a, input logic [7:0] v);
        logic [15:0] dummy;
        xfer(1'b1, {1'b0, a, v}, 1'b0, dummy);
    endtask

    task automatic reg_read(input logic [6:0] a, output logic [15:0] dout);
        xfer(1'b1, {1'b1, a, 8'h00}, 1'b0, dout);
    endtask

    task automatic t_reset;
        logic [15:0] r;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 sclk in reset", sclk_o, 0);
        chk("R1 fs in reset", fs_o, 0);
        chk("R1 sdout in reset", sdout_o, 0);
        chk("R1 valid in reset", tx_valid_o, 0);
        do_reset(1'b0, 1'b0, 1'b0);
        chk("R1 sclk after reset", sclk_o, 0);
        chk("R9 fe_en reset value", fe_en_o, 0);
        reg_read(7'd0, r);
        chk("R9 R10 reg0 reads 08h with fe off", r, 16'h0008);
        reg_read(7'd5, r);
        chk("R9 reg5 reads 00h", r, 16'h0000);
    endtask

    task automatic t_data_late;
        logic [15:0] r;
        do_reset(1'b0, 1'b0, 1'b0);
        rx_sample_i = 16'hA5C3;
        xfer(1'b0, 16'h1234, 1'b0, r);
        chk("R3 sdout word", r, 16'hA5C3);
        chk("R4 late sync on first bit", sd_at_fs, 1);
        chk("R3 tx word", tx_sample_o, 16'h1234);
        chk("R3 tx valid pulse", valid_seen, 1);
        rx_sample_i = 16'h0001;
        xfer(1'b0, 16'hFFFF, 1'b0, r);
        chk("R3 sdout word 2", r, 16'h0001);
        chk("R3 tx word 2", tx_sample_o, 16'hFFFF);
        xfer(1'b0, 16'h8E71, 1'b1, r);
        chk("R11 sdin sampled at falling edge", tx_sample_o, 16'h8E71);
    endtask

    task automatic t_data_early;
        logic [15:0] r;
        do_reset(1'b1, 1'b0, 1'b0);
        rx_sample_i = 16'h8001;
        xfer(1'b0, 16'h5AA5, 1'b0, r);
        chk("R4 early sync before first bit", sd_at_fs, 0);
        chk("R4 early data word", r, 16'h8001);
        chk("R3 early tx word", tx_sample_o, 16'h5AA5);
    endtask

    task automatic t_timing(input bit pos);
        int t0, t1, t2;
        do_reset(1'b0, pos, 1'b0);
        wait_fs(1'b0);
        t0 = cyc;
        wait_fs(1'b1);
        t1 = cyc;
        wait_fs(1'b0);
        t2 = cyc;
        chk("R2 data sync period", t2 - t0, 2 * PERIOD);
        chk("R5 control offset", t1 - t0, pos ? PERIOD / 2 : PERIOD);
    endtask

    task automatic t_stop(input bit early, input bit stop);
        int edges;
        logic [15:0] r;
        do_reset(early, 1'b0, stop);
        wait_fs(1'b0);
        edges = 1;
        forever begin
            @(posedge sclk_o);
            #2;
            if (fs_o) break;
            edges++;
        end
        chk("R6 sclk edges between syncs", edges, stop ? 32 : PERIOD / 2);
        rx_sample_i = 16'h3C96;
        xfer(1'b0, 16'hC3E1, 1'b0, r);
        chk("R6 data frame with sclk stop", r, 16'h3C96);
    endtask

    task automatic t_ctrl;
        logic [15:0] r;
        do_reset(1'b0, 1'b1, 1'b0);
        reg_write(7'd3, 8'h5A);
        reg_read(7'd3, r);
        chk("R7 write then read reg3", r, 16'h005A);
        reg_write(7'h7F, 8'hFF);
        reg_read(7'h7F, r);
        chk("R7 out of range reads zero", r, 16'h0000);
        reg_read(7'd3, r);
        chk("R7 reg3 kept", r, 16'h005A);
    endtask

    task automatic t_commit;
        logic [15:0] r;
        do_reset(1'b0, 1'b0, 1'b1);
        reg_write(7'd0, 8'h88);
        chk("R8 no commit before 16th bit", fe_mid, 0);
        chk("R8 R9 fe_en after write", fe_en_o, 1);
        reg_write(7'd0, 8'h08);
        chk("R8 old value until 16th bit", fe_mid, 1);
        chk("R9 fe_en cleared", fe_en_o, 0);
        reg_read(7'd0, r);
        chk("R10 read with fe off", r, 16'h0008);
    endtask

    initial begin
        t_reset();
        t_data_late();
        t_data_early();
        t_timing(1'b0);
        t_timing(1'b1);
        t_stop(1'b0, 1'b1);
        t_stop(1'b1, 1'b1);
        t_stop(1'b0, 1'b0);
        t_ctrl();
        t_commit();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule